// File: doc/BRIEF.md
# APIC Access Virtualization Filter

This block sits beside the guest load/store path. It is consulted each time a guest access lands on the page that mirrors the local interrupt controller. For every request it decides whether the access is served locally from a shadow copy of the controller registers or must be handed to the hypervisor as an APIC-access exit. The decision depends on the byte offset, the access size, the direction and three control bits:

- TPR shadowing, which enables any virtualization at all;
- register virtualization, which opens most registers;
- virtual-interrupt delivery, which opens a few write targets.

A request presented with `req_valid` is answered exactly one clock later with `rsp_valid`. The answer carries one of three things:

- for a served read, the size-masked read data;
- for a served write, nothing extra, but the write updates the shadow registers, records the written offset and raises a pending-update flag;
- for a refused access, a 64-bit exit qualification.

While the pending-update flag is up, every access is refused. The later TPR/EOI processing finishes the operation and clears the flag through `pend_clear`.

Top module: `apic_access_filter`

## Requirements
- R1: When `ctl_tpr_shadow` is 0, every access is intercepted.
- R2: An access is intercepted when its size is 0 or larger than 4 bytes, or when its offset is 0x3F4 or higher.
- R3: An access is intercepted when the last byte it touches (offset + size - 1) has bit 2 or bit 3 set.
- R4: While `pend_flag` is 1 at the request, the access is intercepted and changes no state.
- R5: With `ctl_reg_virt` set, a read is served only if its offset with bits 1:0 cleared is one of 0x020, 0x030, 0x080, 0x0B0, 0x0D0, 0x0E0, 0x0F0, 0x100 to 0x280 in steps of 0x10, or 0x300 to 0x380 in steps of 0x10, or 0x3E0.
- R6: With `ctl_reg_virt` set, a write is served only if its offset with bits 1:0 cleared is one of 0x020, 0x080, 0x0B0, 0x0D0, 0x0E0, 0x0F0, 0x280, 0x300 to 0x380 in steps of 0x10, or 0x3E0.
- R7: With `ctl_reg_virt` clear and `ctl_int_deliv` set, a write is served only at exactly 0x080, 0x0B0 or 0x300.
- R8: With `ctl_reg_virt` clear, a read is served only at exactly 0x080. With both `ctl_reg_virt` and `ctl_int_deliv` clear, a write is served only at exactly 0x080.
- R9: For an intercepted access, `rsp_qual` holds the offset in bits 11:0 and the type in bits 15:12, with bits 63:16 zero. The type is 3 when `in_event_delivery` is set, otherwise 0 for a read and 1 for a write. For a served access `rsp_qual` is 0.
- R10: A served read returns the shadow bytes starting at the offset, byte 0 in bits 7:0. The value is masked to the size: 0xFF, 0xFFFF, 0xFFFFFF or 0xFFFFFFFF. All other responses return 0.
- R11: A served write stores all four bytes of `req_wdata` starting at the offset, dropping any byte that falls beyond the low 4 bytes of its 16-byte slot. It sets `pend_flag` and loads `write_offset` with the zero-extended offset. Shadow registers reset to 0.
- R12: `pend_clear` clears `pend_flag` on the next edge unless a served write sets it on the same edge, in which case the flag stays set.
- R13: `rsp_valid`, `rsp_intercept`, `rsp_qual` and `rsp_rdata` are registered. They reflect the request of the previous cycle and are 0 when there was none. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_offset | input | 12 | Byte offset within the page |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data, byte 0 in bits 7:0 |
| ctl_tpr_shadow | input | 1 | TPR shadowing enabled |
| ctl_reg_virt | input | 1 | Register virtualization enabled |
| ctl_int_deliv | input | 1 | Virtual-interrupt delivery enabled |
| in_event_delivery | input | 1 | Access happens during event delivery |
| pend_clear | input | 1 | Clear the pending-update flag |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_intercept | output | 1 | Access must raise an exit |
| rsp_qual | output | 64 | Exit qualification |
| rsp_rdata | output | 32 | Served read data |
| pend_flag | output | 1 | Pending virtual-APIC update |
| write_offset | output | 16 | Offset of the last served write |

## Verification
Every response output is due on the first rising edge after the request is driven, since the decision, qualification and read data each pass through one register. `pend_flag`, `write_offset` and the shadow storage take effect on that same edge and govern the request of the following cycle. The bench drives each request on a falling edge, computes its expectation from a byte-level model, and samples one time unit after the next rising edge. It compares every output on every clock, idle cycles included. Sequences of a served write, a blocked access, a clear and a read-back show that each state change lands exactly one request later.

// File: rtl/apf_pkg.sv
`timescale 1ns/1ps
package apf_pkg;

   // Register offsets the decision depends on
   localparam logic [11:0] OFS_TPR    = 12'h080;
   localparam logic [11:0] OFS_EOI    = 12'h0B0;
   localparam logic [11:0] OFS_ICR_LO = 12'h300;

   // Access kind encoded in the qualification type field
   typedef enum logic [3:0] {
      ACC_LIN_READ  = 4'd0,
      ACC_LIN_WRITE = 4'd1,
      ACC_LIN_EVENT = 4'd3
   } acc_kind_e;

   localparam int QUAL_TYPE_W = 4;

   // 16-byte slot index -> register readable when register virtualization is on
   function automatic logic slot_read_ok(input logic [5:0] s);
      case (s) inside
         6'h02, 6'h03, 6'h08, 6'h0B, 6'h0D, 6'h0E, 6'h0F,
         [6'h10:6'h28], [6'h30:6'h38], 6'h3E: return 1'b1;
         default:                               return 1'b0;
      endcase
   endfunction

   // 16-byte slot index -> register writable when register virtualization is on
   function automatic logic slot_write_ok(input logic [5:0] s);
      case (s) inside
         6'h02, 6'h08, 6'h0B, 6'h0D, 6'h0E, 6'h0F, 6'h28,
         [6'h30:6'h38], 6'h3E: return 1'b1;
         default:               return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/apf_decide.sv
`timescale 1ns/1ps
module apf_decide
   import apf_pkg::*;
#(
   parameter int OFS_W     = 12,
   parameter int SIZE_W    = 3,
   parameter int MAX_BYTES = 4,
   parameter int REG_END   = 'h3F0
) (
   input  logic [OFS_W-1:0]  offset,
   input  logic [SIZE_W-1:0] size,
   input  logic              is_write,
   input  logic              tpr_shadow,
   input  logic              reg_virt,
   input  logic              int_deliv,
   input  logic              pend,
   output logic              intercept
);

   localparam int NUM_SLOTS = REG_END / 16;
   localparam int SLOT_W    = $clog2(NUM_SLOTS);
   localparam int LIMIT     = REG_END + MAX_BYTES;

   if (SLOT_W > 6) begin : g_bad_end
      $error("apf_decide: register area larger than slot tables");
   end

   logic [3:0]        last_lo;
   logic              size_bad, straddle, beyond;
   logic              in_area, slot_aligned;
   logic [5:0]        slot;
   logic              rd_ok, wr_ok, wr_vid_ok;
   logic              exact_tpr;

   always_comb begin
      size_bad     = (size == '0) || (int'(size) > MAX_BYTES);
      last_lo      = offset[3:0] + 4'(size) - 4'd1;
      straddle     = (last_lo & 4'hC) != 4'h0;
      beyond       = int'(offset) >= LIMIT;
      in_area      = int'(offset[OFS_W-1:4]) < NUM_SLOTS;
      slot_aligned = offset[3:2] == 2'b00;
      slot         = 6'(offset[SLOT_W+3:4]);
      exact_tpr    = offset == OFS_W'(OFS_TPR);
      wr_vid_ok    = (offset == OFS_W'(OFS_TPR)) ||
                     (offset == OFS_W'(OFS_EOI)) ||
                     (offset == OFS_W'(OFS_ICR_LO));

      if (reg_virt) begin
         rd_ok = in_area && slot_aligned && slot_read_ok(slot);
         wr_ok = in_area && slot_aligned && slot_write_ok(slot);
      end else begin
         rd_ok = exact_tpr;
         wr_ok = int_deliv ? wr_vid_ok : exact_tpr;
      end

      intercept = !tpr_shadow || size_bad || straddle || beyond || pend ||
                  !(is_write ? wr_ok : rd_ok);
   end

endmodule

// File: rtl/apf_vregs.sv
`timescale 1ns/1ps
module apf_vregs #(
   parameter int  DATA_W         = 32,
   parameter int  NUM_SLOTS      = 63,
   parameter int  SIZE_W         = 3,
   parameter bit  CLEAR_ON_RESET = 1'b1,
   localparam int SLOT_W         = $clog2(NUM_SLOTS),
   localparam int NBYTES         = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] slot,
   input  logic [1:0]        byte_sel,
   input  logic [SIZE_W-1:0] size,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data
);

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("apf_vregs: data width must be whole bytes");
   end

   logic [NUM_SLOTS-1:0][DATA_W-1:0] words;
   logic [DATA_W-1:0]                merged, keep, cur, size_mask;
   logic [4:0]                       shamt;

   always_comb begin
      shamt  = {byte_sel, 3'b000};
      cur    = (int'(slot) < NUM_SLOTS) ? words[slot] : '0;
      keep   = ~({DATA_W{1'b1}} << shamt);
      merged = (cur & keep) | (wdata << shamt);
      for (int i = 0; i < NBYTES; i++) begin
         size_mask[8*i +: 8] = {8{i < int'(size)}};
      end
      rd_data = (cur >> shamt) & size_mask;
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic [DATA_W-1:0] word_q;
      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)                                   word_q <= '0;
            else if (wr_en && slot == SLOT_W'(g))         word_q <= merged;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wr_en && slot == SLOT_W'(g))              word_q <= merged;
         end
      end
      assign words[g] = word_q;
   end

   // R11: an aligned write leaves the full data word in its slot
   a_r11_full_word: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && byte_sel == 2'b00 && int'(slot) < NUM_SLOTS
      |=> words[$past(slot)] == $past(wdata));

endmodule

// File: rtl/apf_pending.sv
`timescale 1ns/1ps
module apf_pending #(
   parameter int OFS_W  = 12,
   parameter int WOFS_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic              clr,
   input  logic [OFS_W-1:0]  set_offset,
   output logic              pend_q,
   output logic [WOFS_W-1:0] woff_q
);

   if (WOFS_W < OFS_W) begin : g_bad_w
      $error("apf_pending: offset register too narrow");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         woff_q <= '0;
      end else begin
         if (set) begin
            pend_q <= 1'b1;
            woff_q <= WOFS_W'(set_offset);
         end else if (clr) begin
            pend_q <= 1'b0;
         end
      end
   end

   // R11: a served write raises the flag and records its offset
   a_r11_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> pend_q && woff_q == WOFS_W'($past(set_offset)));

   // R12: clear without a simultaneous set drops the flag
   a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !set |=> !pend_q);

   // R12: a simultaneous set wins over clear
   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr && set |=> pend_q);

endmodule

// File: rtl/apic_access_filter.sv
`timescale 1ns/1ps
module apic_access_filter
   import apf_pkg::*;
#(
   parameter int OFS_W     = 12,
   parameter int SIZE_W    = 3,
   parameter int DATA_W    = 32,
   parameter int QUAL_W    = 64,
   parameter int WOFS_W    = 16,
   parameter int REG_END   = 'h3F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [OFS_W-1:0]  req_offset,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ctl_tpr_shadow,
   input  logic              ctl_reg_virt,
   input  logic              ctl_int_deliv,
   input  logic              in_event_delivery,
   input  logic              pend_clear,
   output logic              rsp_valid,
   output logic              rsp_intercept,
   output logic [QUAL_W-1:0] rsp_qual,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              pend_flag,
   output logic [WOFS_W-1:0] write_offset
);

   localparam int MAX_BYTES = DATA_W / 8;
   localparam int NUM_SLOTS = REG_END / 16;
   localparam int SLOT_W    = $clog2(NUM_SLOTS);

   if (OFS_W != 12) begin : g_bad_ofs
      $error("apic_access_filter: qualification layout needs a 12-bit offset");
   end
   if (QUAL_W < OFS_W + QUAL_TYPE_W) begin : g_bad_qual
      $error("apic_access_filter: qualification too narrow");
   end
   if (MAX_BYTES != 4) begin : g_bad_data
      $error("apic_access_filter: slot rules assume 4-byte registers");
   end

   logic              intercept_c;
   logic              serve_rd, serve_wr;
   logic [DATA_W-1:0] vreg_rd;
   acc_kind_e         kind;
   logic [QUAL_W-1:0] qual_c;

   apf_decide #(
      .OFS_W(OFS_W), .SIZE_W(SIZE_W), .MAX_BYTES(MAX_BYTES), .REG_END(REG_END)
   ) u_decide (
      .offset     (req_offset),
      .size       (req_size),
      .is_write   (req_write),
      .tpr_shadow (ctl_tpr_shadow),
      .reg_virt   (ctl_reg_virt),
      .int_deliv  (ctl_int_deliv),
      .pend       (pend_flag),
      .intercept  (intercept_c)
   );

   assign serve_rd = req_valid && !intercept_c && !req_write;
   assign serve_wr = req_valid && !intercept_c &&  req_write;

   apf_vregs #(
      .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SIZE_W(SIZE_W), .CLEAR_ON_RESET(1'b1)
   ) u_vregs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (serve_wr),
      .slot     (req_offset[SLOT_W+3:4]),
      .byte_sel (req_offset[1:0]),
      .size     (req_size),
      .wdata    (req_wdata),
      .rd_data  (vreg_rd)
   );

   apf_pending #(
      .OFS_W(OFS_W), .WOFS_W(WOFS_W)
   ) u_pending (
      .clk        (clk),
      .rst_n      (rst_n),
      .set        (serve_wr),
      .clr        (pend_clear),
      .set_offset (req_offset),
      .pend_q     (pend_flag),
      .woff_q     (write_offset)
   );

   always_comb begin
      if (in_event_delivery) kind = ACC_LIN_EVENT;
      else if (req_write)    kind = ACC_LIN_WRITE;
      else                   kind = ACC_LIN_READ;
      qual_c = '0;
      qual_c[OFS_W-1:0]               = req_offset;
      qual_c[OFS_W +: QUAL_TYPE_W]    = kind;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_intercept <= 1'b0;
         rsp_qual      <= '0;
         rsp_rdata     <= '0;
      end else begin
         rsp_valid     <= req_valid;
         rsp_intercept <= req_valid && intercept_c;
         rsp_qual      <= (req_valid && intercept_c) ? qual_c : '0;
         rsp_rdata     <= serve_rd ? vreg_rd : '0;
      end
   end

   // R1: no TPR shadowing means every access exits
   a_r1_no_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !ctl_tpr_shadow |=> rsp_valid && rsp_intercept);

   // R2: illegal size always exits
   a_r2_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_size == '0 || int'(req_size) > MAX_BYTES) |=> rsp_intercept);

   // R4: a pending update blocks the next access
   a_r4_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && pend_flag |=> rsp_intercept);

   // R9: upper qualification bits stay clear, and served accesses carry none
   a_r9_qual_upper: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_qual[QUAL_W-1:OFS_W+QUAL_TYPE_W] == '0);
   a_r9_qual_only_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_intercept |-> rsp_qual == '0);

   // R10: single-byte reads return only one byte
   a_r10_byte_mask: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_size == SIZE_W'(1) |=> rsp_rdata[DATA_W-1:8] == '0);

   // R13: a response follows each request and only a request
   a_r13_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r13_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_intercept);

endmodule

// File: tb/tb_apic_access_filter.sv
`timescale 1ns/1ps
module tb_apic_access_filter;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [11:0] req_offset;
   logic [2:0]  req_size;
   logic        req_write;
   logic [31:0] req_wdata;
   logic        ctl_tpr_shadow, ctl_reg_virt, ctl_int_deliv;
   logic        in_event_delivery, pend_clear;
   logic        rsp_valid, rsp_intercept;
   logic [63:0] rsp_qual;
   logic [31:0] rsp_rdata;
   logic        pend_flag;
   logic [15:0] write_offset;

   always #2.5 clk = ~clk;

   apic_access_filter dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .ctl_tpr_shadow(ctl_tpr_shadow), .ctl_reg_virt(ctl_reg_virt),
      .ctl_int_deliv(ctl_int_deliv), .in_event_delivery(in_event_delivery),
      .pend_clear(pend_clear), .rsp_valid(rsp_valid), .rsp_intercept(rsp_intercept),
      .rsp_qual(rsp_qual), .rsp_rdata(rsp_rdata), .pend_flag(pend_flag),
      .write_offset(write_offset)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   // Behavioural model state
   bit [7:0]  vbyte [0:1023];
   bit        m_pend;
   bit [15:0] m_woff;
   int        rd_set[$];
   int        wr_set[$];

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic bit member(int q[$], int v);
      foreach (q[i]) if (q[i] == v) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit model_exit(int off, int sz, bit wr, bit tpr, bit rv, bit vid);
      if (!tpr) return 1;
      if (sz < 1 || sz > 4) return 1;
      if ((((off + sz - 1) & 'hC)) != 0) return 1;
      if (off >= 'h3F4) return 1;
      if (m_pend) return 1;
      if (!wr) return rv ? !member(rd_set, off & ~3) : (off != 'h080);
      if (rv)  return !member(wr_set, off & ~3);
      if (vid) return !(off == 'h080 || off == 'h0B0 || off == 'h300);
      return off != 'h080;
   endfunction

   task automatic step(bit v, int off, int sz, bit wr, bit [31:0] wd,
                       bit tpr, bit rv, bit vid, bit ev, bit clr, string tag);
      bit        icpt;
      bit [63:0] eq;
      bit [31:0] ed;
      bit        np;
      bit [15:0] nw;
      @(negedge clk);
      req_valid = v; req_offset = 12'(off); req_size = 3'(sz); req_write = wr;
      req_wdata = wd; ctl_tpr_shadow = tpr; ctl_reg_virt = rv; ctl_int_deliv = vid;
      in_event_delivery = ev; pend_clear = clr;
      icpt = v ? model_exit(off, sz, wr, tpr, rv, vid) : 1'b0;
      eq = 64'd0; ed = 32'd0; np = m_pend; nw = m_woff;
      if (v && icpt) eq = (64'(ev ? 3 : (wr ? 1 : 0)) << 12) | 64'(off & 'hFFF);
      if (v && !icpt && !wr)
         for (int i = 0; i < sz; i++) ed |= 32'(vbyte[off + i]) << (8 * i);
      if (v && !icpt && wr) begin
         np = 1'b1; nw = 16'(off);
      end else if (clr) begin
         np = 1'b0;
      end
      @(posedge clk);
      #1;
      chk(rsp_valid == v,       "R13", {tag, " valid"},     64'(rsp_valid), 64'(v));
      chk(rsp_intercept == icpt, tag,  "intercept",          64'(rsp_intercept), 64'(icpt));
      chk(rsp_qual == eq,       "R9",  {tag, " qual"},      rsp_qual, eq);
      chk(rsp_rdata == ed,      "R10", {tag, " rdata"},     64'(rsp_rdata), 64'(ed));
      chk(pend_flag == np,      "R12", {tag, " pend"},      64'(pend_flag), 64'(np));
      chk(write_offset == nw,   "R11", {tag, " woff"},      64'(write_offset), 64'(nw));
      if (v && !icpt && wr)
         for (int i = 0; i < 4; i++)
            if ((((off + i) & 'hC)) == 0 && off + i < 1024) vbyte[off + i] = wd[8*i +: 8];
      m_pend = np; m_woff = nw;
   endtask

   task automatic idle(string tag);
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, tag);
   endtask

   task automatic clear_pend();
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R12 clear");
   endtask

   initial begin
      // Allow-lists built from the register map
      foreach (vbyte[i]) vbyte[i] = 8'h00;
      rd_set = {'h020, 'h030, 'h080, 'h0B0, 'h0D0, 'h0E0, 'h0F0, 'h3E0};
      for (int a = 'h100; a <= 'h280; a += 'h10) rd_set.push_back(a);
      for (int a = 'h300; a <= 'h380; a += 'h10) rd_set.push_back(a);
      wr_set = {'h020, 'h080, 'h0B0, 'h0D0, 'h0E0, 'h0F0, 'h280, 'h3E0};
      for (int a = 'h300; a <= 'h380; a += 'h10) wr_set.push_back(a);
      m_pend = 0; m_woff = 0;

      rst_n = 0; req_valid = 0; req_offset = 0; req_size = 0; req_write = 0;
      req_wdata = 0; ctl_tpr_shadow = 0; ctl_reg_virt = 0; ctl_int_deliv = 0;
      in_event_delivery = 0; pend_clear = 0;
      repeat (3) @(negedge clk);
      // R13: reset state
      chk(!rsp_valid && !rsp_intercept && rsp_qual == 0 && rsp_rdata == 0 &&
          !pend_flag && write_offset == 0, "R13", "reset outputs",
          64'(rsp_valid | rsp_intercept | pend_flag), 0);
      rst_n = 1;

      idle("R13 idle");
      // R1: no shadow, read TPR exits with read type
      step(1, 'h080, 4, 0, 0, 0, 0, 0, 0, 0, "R1");
      chk(rsp_qual == 64'h080, "R9", "read qual literal", rsp_qual, 64'h080);
      // R8/R11: TPR-only mode write served
      step(1, 'h080, 4, 1, 32'h12345678, 1, 0, 0, 0, 0, "R8 tpr write");
      // R4: pending flag blocks next access
      step(1, 'h080, 4, 0, 0, 1, 0, 0, 0, 0, "R4 blocked read");
      step(1, 'h080, 4, 1, 32'hDEADBEEF, 1, 0, 0, 0, 0, "R4 blocked write");
      clear_pend();
      // R10: size masking
      step(1, 'h080, 1, 0, 0, 1, 0, 0, 0, 0, "R10 size1");
      chk(rsp_rdata == 32'h78, "R10", "byte literal", 64'(rsp_rdata), 64'h78);
      step(1, 'h080, 2, 0, 0, 1, 0, 0, 0, 0, "R10 size2");
      step(1, 'h080, 3, 0, 0, 1, 0, 0, 0, 0, "R10 size3");
      step(1, 'h080, 4, 0, 0, 1, 0, 0, 0, 0, "R10 size4");
      chk(rsp_rdata == 32'h12345678, "R10", "word literal", 64'(rsp_rdata), 64'h12345678);
      // R8: TPR-only mode rejects others
      step(1, 'h030, 4, 0, 0, 1, 0, 0, 0, 0, "R8 read ver");
      step(1, 'h0B0, 4, 1, 1, 1, 0, 0, 0, 0, "R8 write eoi");
      chk(rsp_qual == 64'h10B0, "R9", "write qual literal", rsp_qual, 64'h10B0);
      step(1, 'h0B0, 4, 1, 1, 1, 0, 0, 1, 0, "R9 event type");
      chk(rsp_qual == 64'h30B0, "R9", "event qual literal", rsp_qual, 64'h30B0);
      // R5: register virtualization reads
      step(1, 'h030, 4, 0, 0, 1, 1, 0, 0, 0, "R5 version");
      step(1, 'h2F0, 4, 0, 0, 1, 1, 0, 0, 0, "R5 unlisted");
      step(1, 'h390, 4, 0, 0, 1, 1, 0, 0, 0, "R5 current count");
      step(1, 'h101, 1, 0, 0, 1, 1, 0, 0, 0, "R5 isr byte");
      step(1, 'h270, 4, 0, 0, 1, 1, 0, 0, 0, "R5 irr7");
      step(1, 'h082, 2, 0, 0, 1, 1, 0, 0, 0, "R5 tpr upper half");
      chk(rsp_rdata == 32'h1234, "R10", "shifted half", 64'(rsp_rdata), 64'h1234);
      // R3: straddling the low four bytes
      step(1, 'h082, 4, 0, 0, 1, 1, 0, 0, 0, "R3 straddle");
      step(1, 'h08D, 4, 0, 0, 1, 1, 0, 0, 0, "R3 slot cross");
      // R6: register virtualization writes
      step(1, 'h030, 4, 1, 5, 1, 1, 0, 0, 0, "R6 version ro");
      step(1, 'h102, 2, 1, 5, 1, 1, 0, 0, 0, "R6 isr ro");
      step(1, 'h3E0, 4, 1, 32'h0000000B, 1, 1, 0, 0, 0, "R6 divide");
      clear_pend();
      step(1, 'h3E0, 4, 0, 0, 1, 1, 0, 0, 0, "R6 divide readback");
      step(1, 'h0D1, 1, 1, 32'h11223344, 1, 1, 0, 0, 0, "R11 spill write");
      clear_pend();
      step(1, 'h0D0, 4, 0, 0, 1, 1, 0, 0, 0, "R11 spill readback");
      chk(rsp_rdata == 32'h22334400, "R11", "spill literal", 64'(rsp_rdata), 64'h22334400);
      // R7: virtual-interrupt delivery only
      step(1, 'h300, 4, 1, 32'hCAFE0001, 1, 0, 1, 0, 0, "R7 icr lo");
      chk(write_offset == 16'h0300, "R11", "woff literal", 64'(write_offset), 64'h300);
      clear_pend();
      step(1, 'h301, 1, 1, 7, 1, 0, 1, 0, 0, "R7 inner byte");
      step(1, 'h310, 4, 1, 7, 1, 0, 1, 0, 0, "R7 icr hi");
      step(1, 'h0B0, 4, 1, 0, 1, 0, 1, 0, 0, "R7 eoi");
      clear_pend();
      step(1, 'h300, 4, 0, 0, 1, 0, 1, 0, 0, "R8 vid read");
      // R2: size and range limits
      step(1, 'h080, 5, 0, 0, 1, 1, 0, 0, 0, "R2 wide");
      step(1, 'h080, 0, 0, 0, 1, 1, 0, 0, 0, "R2 zero");
      step(1, 'h3F4, 1, 0, 0, 1, 1, 0, 0, 0, "R2 beyond");
      step(1, 'h800, 1, 1, 0, 1, 1, 0, 0, 0, "R2 high page");
      // R12: set wins over simultaneous clear
      step(1, 'h080, 4, 1, 32'h40, 1, 1, 0, 0, 1, "R12 set wins");
      chk(pend_flag == 1'b1, "R12", "flag held", 64'(pend_flag), 1);
      clear_pend();
      idle("R13 trailing");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R13 watchdog: actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule